// File: doc/BRIEF.md
# Multiplexed CV refresh sequencer

This block moves values from one shared DAC into many sample-and-hold control-voltage channels, one channel at a time. A requester presents a channel number, a DAC code and a profile bit. The block latches them, loads the DAC, lets the DAC output settle, then enables the analog demultiplexer on the target channel so the hold capacitor can charge. It then closes the demultiplexer and can wait again before it takes the next request.

The wait lengths are counted in time units of 250 ns, which a prescaler derives from the system clock (`TICK_DIV` clocks per unit). There are two timing profiles. The fast profile serves voltages that are refreshed every cycle of a 2 kHz loop: oscillator pitch, filter cutoff and amplitude. Its three wait counts come from an input word, so margin can be added for slow multiplexers, for example 1/1/1 or 1/2/2 instead of the usual 1/1/0. The normal profile serves every other voltage and uses fixed counts of 4, 8 and 8 units. A rate monitor counts completed fast-profile updates in each fixed window of clock cycles, so the refresh rate can be measured.

Top module: `cv_refresh_seq`

## Requirements
- R1: While reset is applied and in the first cycle after it, `busy`, `mux_en` and `dac_load` are low and `rate_count` is zero.
- R2: A request is accepted at a clock edge where `req_valid` is high and `busy` is low. In the next cycle `dac_load` is high for exactly one cycle, `busy` is high, `dac_data` equals the requested code and `mux_addr` equals the requested channel.
- R3: After the load cycle the block holds `mux_en` low for S×D cycles (settle phase). It then holds `mux_en` high for max(1, H×D) consecutive cycles (select phase). It then keeps `busy` high with `mux_en` low for T×D cycles (tail phase), and then lowers `busy`. D is `TICK_DIV`. S, H and T are the settle, select and tail counts of the profile.
- R4: With `req_fast` low the counts are S=4, H=8, T=8. `fast_waits` has no effect, so with D=4 `busy` stays high for 81 cycles and `mux_en` first rises in cycle 18 after acceptance.
- R5: With `req_fast` high the counts come from `fast_waits`: S in bits [3:0], H in bits [7:4], T in bits [11:8]. They are sampled at acceptance. A value of 0x011 gives 1/1/0 and `busy` stays high for 9 cycles when D=4.
- R6: A count of zero skips its phase. With S=0, `mux_en` rises in the cycle right after the load cycle. With T=0, `busy` falls in the cycle right after `mux_en` falls. With H=0, `mux_en` is high for a single cycle.
- R7: While `busy` is high after the load cycle, `dac_data` and `mux_addr` do not change. Changes on `req_chan`, `req_code`, `req_fast` and `fast_waits` during that time have no effect on the update in progress.
- R8: A request held on `req_valid` while `busy` is high is not lost. It is accepted at the edge that ends the first cycle with `busy` low, so exactly one idle cycle separates the two updates.
- R9: At the end of each window of `WIN_CYCLES` clocks (the first window starts when reset is released), `rate_count` is set to the number of fast-profile updates that finished within that window. Normal-profile updates are not counted. `rate_count` holds that value for the whole next window.
- R10: The count saturates at 2^`RATE_W`−1 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Update request, held until accepted |
| req_chan | input | CH_W | Target CV channel |
| req_code | input | DAC_W | DAC code for the channel |
| req_fast | input | 1 | 1 selects the fast profile, 0 the normal profile |
| fast_waits | input | 12 | Fast-profile counts: tail [11:8], select [7:4], settle [3:0] |
| dac_data | output | DAC_W | Code driven to the DAC |
| dac_load | output | 1 | One-cycle DAC load strobe |
| mux_addr | output | CH_W | Demultiplexer channel address |
| mux_en | output | 1 | Demultiplexer enable, high only during the select phase |
| busy | output | 1 | Update in progress; requests are held off while high |
| rate_count | output | RATE_W | Fast-profile updates finished in the last window |

## Verification
A wrong phase state or a wrong unit counter shows up as a select pulse that starts at the wrong cycle or lasts the wrong number of cycles, or as a `busy` period of the wrong length. Each of these is visible within the same update, so the bench measures all of them against the cycle counts of R3 to R6. Latched-field errors show at once as a changed `dac_data` or `mux_addr` during `busy`. Rate-counter errors appear only one window later, so the bench aligns its checks to reset release and reads two consecutive windows.

// File: rtl/cvr_pkg.sv
package cvr_pkg;
  localparam int WAIT_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SETTLE,
    ST_SELECT,
    ST_TAIL
  } cvr_state_e;

  typedef struct packed {
    logic [WAIT_W-1:0] tail;
    logic [WAIT_W-1:0] hold;
    logic [WAIT_W-1:0] settle;
  } cvr_waits_t;
endpackage

// File: rtl/cvr_unit_timer.sv
module cvr_unit_timer
  import cvr_pkg::*;
#(
  parameter int TICK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WAIT_W-1:0] units,
  output logic              last
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(TICK_DIV - 1);

  logic [WAIT_W-1:0] rem;
  logic [PRE_W-1:0]  pre;

  // rem counts remaining units; pre counts clocks inside the current unit
  always_ff @(posedge clk) begin
    if (rst) begin
      rem <= '0;
      pre <= '0;
    end else if (load) begin
      rem <= units;
      pre <= PRE_TOP;
    end else if (rem != '0) begin
      if (pre == '0) begin
        pre <= PRE_TOP;
        rem <= rem - 1'b1;
      end else begin
        pre <= pre - 1'b1;
      end
    end
  end

  assign last = (rem == '0) || ((rem == WAIT_W'(1)) && (pre == '0));

  assert_timer_monotonic_R3: assert property (@(posedge clk) disable iff (rst)
    (!load && rem != '0) |=> (rem <= $past(rem)));
endmodule

// File: rtl/cvr_seq_fsm.sv
module cvr_seq_fsm
  import cvr_pkg::*;
#(
  parameter int CH_W        = 4,
  parameter int DAC_W       = 12,
  parameter int TICK_DIV    = 4,
  parameter int NORM_SETTLE = 4,
  parameter int NORM_HOLD   = 8,
  parameter int NORM_TAIL   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [CH_W-1:0]  req_chan,
  input  logic [DAC_W-1:0] req_code,
  input  logic             req_fast,
  input  cvr_waits_t       fast_waits,
  output logic [DAC_W-1:0] dac_data,
  output logic             dac_load,
  output logic [CH_W-1:0]  mux_addr,
  output logic             mux_en,
  output logic             busy,
  output logic             fast_done
);
  localparam cvr_waits_t NORM_WAITS = '{
    tail:   WAIT_W'(NORM_TAIL),
    hold:   WAIT_W'(NORM_HOLD),
    settle: WAIT_W'(NORM_SETTLE)
  };

  cvr_state_e        st, st_n;
  cvr_waits_t        w_q;
  logic              fast_q;
  logic              tmr_load, tmr_last;
  logic [WAIT_W-1:0] tmr_units;
  logic              accept;

  assign accept = (st == ST_IDLE) && req_valid;

  cvr_unit_timer #(.TICK_DIV(TICK_DIV)) i_timer (
    .clk   (clk),
    .rst   (rst),
    .load  (tmr_load),
    .units (tmr_units),
    .last  (tmr_last)
  );

  always_comb begin
    st_n      = st;
    tmr_load  = 1'b0;
    tmr_units = '0;
    unique case (st)
      ST_IDLE: if (req_valid) st_n = ST_LOAD;
      ST_LOAD: begin
        tmr_load = 1'b1;
        if (w_q.settle != '0) begin
          st_n      = ST_SETTLE;
          tmr_units = w_q.settle;
        end else begin
          st_n      = ST_SELECT;
          tmr_units = w_q.hold;
        end
      end
      ST_SETTLE: if (tmr_last) begin
        st_n      = ST_SELECT;
        tmr_load  = 1'b1;
        tmr_units = w_q.hold;
      end
      ST_SELECT: if (tmr_last) begin
        if (w_q.tail != '0) begin
          st_n      = ST_TAIL;
          tmr_load  = 1'b1;
          tmr_units = w_q.tail;
        end else begin
          st_n = ST_IDLE;
        end
      end
      ST_TAIL: if (tmr_last) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      w_q       <= '0;
      fast_q    <= 1'b0;
      dac_data  <= '0;
      mux_addr  <= '0;
      dac_load  <= 1'b0;
      mux_en    <= 1'b0;
      busy      <= 1'b0;
      fast_done <= 1'b0;
    end else begin
      st        <= st_n;
      dac_load  <= (st_n == ST_LOAD);
      mux_en    <= (st_n == ST_SELECT);
      busy      <= (st_n != ST_IDLE);
      fast_done <= fast_q && (st != ST_IDLE) && (st_n == ST_IDLE);
      if (accept) begin
        w_q      <= req_fast ? fast_waits : NORM_WAITS;
        fast_q   <= req_fast;
        dac_data <= req_code;
        mux_addr <= req_chan;
      end
    end
  end

  assert_sel_inside_busy_R3: assert property (@(posedge clk) disable iff (rst)
    mux_en |-> busy);
  assert_load_once_R2: assert property (@(posedge clk) disable iff (rst)
    dac_load |=> (!dac_load && busy));
  assert_fields_held_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && !dac_load) |-> ($stable(dac_data) && $stable(mux_addr)));
  assert_accept_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> dac_load);
  assert_sel_after_load_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(mux_en) |-> !dac_load);
endmodule

// File: rtl/cvr_rate_mon.sv
module cvr_rate_mon #(
  parameter int WIN_CYCLES = 16000,
  parameter int RATE_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fast_done,
  output logic [RATE_W-1:0] rate_count
);
  localparam int WC_W = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [WC_W-1:0]   WC_LAST = WC_W'(WIN_CYCLES - 1);
  localparam logic [RATE_W-1:0] SAT     = {RATE_W{1'b1}};

  logic [WC_W-1:0]   wcnt;
  logic [RATE_W-1:0] acc, acc_n;

  assign acc_n = (fast_done && acc != SAT) ? acc + 1'b1 : acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt       <= '0;
      acc        <= '0;
      rate_count <= '0;
    end else if (wcnt == WC_LAST) begin
      wcnt       <= '0;
      acc        <= '0;
      rate_count <= acc_n;
    end else begin
      wcnt <= wcnt + 1'b1;
      acc  <= acc_n;
    end
  end

  assert_rate_saturate_R10: assert property (@(posedge clk) disable iff (rst)
    (acc == SAT && wcnt != WC_LAST) |=> (acc == SAT));
  assert_rate_held_R9: assert property (@(posedge clk) disable iff (rst)
    (wcnt != '0) |-> $stable(rate_count));
endmodule

// File: rtl/cv_refresh_seq.sv
module cv_refresh_seq
  import cvr_pkg::*;
#(
  parameter int CH_W        = 4,
  parameter int DAC_W       = 12,
  parameter int TICK_DIV    = 4,
  parameter int NORM_SETTLE = 4,
  parameter int NORM_HOLD   = 8,
  parameter int NORM_TAIL   = 8,
  parameter int WIN_CYCLES  = 16000,
  parameter int RATE_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [CH_W-1:0]   req_chan,
  input  logic [DAC_W-1:0]  req_code,
  input  logic              req_fast,
  input  logic [11:0]       fast_waits,
  output logic [DAC_W-1:0]  dac_data,
  output logic              dac_load,
  output logic [CH_W-1:0]   mux_addr,
  output logic              mux_en,
  output logic              busy,
  output logic [RATE_W-1:0] rate_count
);
  logic fast_done;

  cvr_seq_fsm #(
    .CH_W(CH_W), .DAC_W(DAC_W), .TICK_DIV(TICK_DIV),
    .NORM_SETTLE(NORM_SETTLE), .NORM_HOLD(NORM_HOLD), .NORM_TAIL(NORM_TAIL)
  ) i_fsm (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_chan   (req_chan),
    .req_code   (req_code),
    .req_fast   (req_fast),
    .fast_waits (cvr_waits_t'(fast_waits)),
    .dac_data   (dac_data),
    .dac_load   (dac_load),
    .mux_addr   (mux_addr),
    .mux_en     (mux_en),
    .busy       (busy),
    .fast_done  (fast_done)
  );

  cvr_rate_mon #(.WIN_CYCLES(WIN_CYCLES), .RATE_W(RATE_W)) i_rate (
    .clk        (clk),
    .rst        (rst),
    .fast_done  (fast_done),
    .rate_count (rate_count)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !mux_en && !dac_load && rate_count == '0));
endmodule

// File: tb/test_cv_refresh_seq.sv
module test_cv_refresh_seq;
  localparam int CLK_PERIOD = 10;
  localparam int D   = 4;
  localparam int CHW = 4;
  localparam int DW  = 12;
  localparam int WIN = 600;
  localparam int RW  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [CHW-1:0] req_chan = '0;
  logic [DW-1:0] req_code = '0;
  logic req_fast = 1'b0;
  logic [11:0] fast_waits = 12'h011;
  logic [DW-1:0] dac_data;
  logic dac_load, mux_en, busy;
  logic [CHW-1:0] mux_addr;
  logic [RW-1:0] rate_count;

  int vec = 0;
  int bad = 0;
  int cyc = 0;
  int rel_cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  cv_refresh_seq #(.CH_W(CHW), .DAC_W(DW), .TICK_DIV(D),
                   .WIN_CYCLES(WIN), .RATE_W(RW)) i_cv_refresh_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_chan(req_chan),
    .req_code(req_code), .req_fast(req_fast), .fast_waits(fast_waits),
    .dac_data(dac_data), .dac_load(dac_load), .mux_addr(mux_addr),
    .mux_en(mux_en), .busy(busy), .rate_count(rate_count));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    rel_cyc = cyc;
    @(negedge clk);
    check(!busy && !mux_en && !dac_load, "R1", "idle after reset",
          {busy, mux_en, dac_load}, 0);
    check(rate_count == 0, "R1", "rate after reset", int'(rate_count), 0);
  endtask

  // one update, measured cycle by cycle after the accepting edge
  task automatic run_update(input logic [CHW-1:0] ch, input logic [DW-1:0] code,
                            input bit fast, input int s, input int h, input int t,
                            input logic [11:0] wword, input string req);
    int first_sel = 0, last_sel = 0, sel_cnt = 0, busy_cnt = 0, load_cnt = 0;
    int moved = 0;
    int es = s * D;
    int eh = (h * D > 1) ? h * D : 1;
    int et = t * D;
    @(negedge clk);
    req_valid = 1'b1; req_chan = ch; req_code = code; req_fast = fast;
    fast_waits = wword;
    @(negedge clk);
    req_valid = 1'b0; req_chan = ~ch; req_code = ~code; req_fast = ~fast;
    fast_waits = ~wword;
    check(dac_load && busy, "R2", "load strobe", {dac_load, busy}, 3);
    check(dac_data == code, "R2", "dac_data", int'(dac_data), int'(code));
    check(mux_addr == ch, "R2", "mux_addr", int'(mux_addr), int'(ch));
    for (int k = 1; k < 400; k++) begin
      if (!busy) break;
      busy_cnt++;
      if (dac_load) load_cnt++;
      if (mux_en) begin
        if (first_sel == 0) first_sel = k;
        last_sel = k;
        sel_cnt++;
      end
      if (dac_data != code || mux_addr != ch) moved++;
      @(negedge clk);
    end
    check(busy_cnt == 1 + es + eh + et, req, "busy length", busy_cnt, 1 + es + eh + et);
    check(first_sel == 2 + es, req, "select start", first_sel, 2 + es);
    check(sel_cnt == eh && last_sel - first_sel + 1 == eh, req, "select length",
          sel_cnt, eh);
    check(load_cnt == 1, "R2", "load count", load_cnt, 1);
    check(moved == 0, "R7", "fields moved during busy", moved, 0);
  endtask

  task automatic test_normal();
    run_update(4'h3, 12'hA5C, 1'b0, 4, 8, 8, 12'h000, "R4");
    run_update(4'hC, 12'h0F1, 1'b0, 4, 8, 8, 12'hFFF, "R4");
  endtask

  task automatic test_fast();
    run_update(4'h1, 12'h123, 1'b1, 1, 1, 0, 12'h011, "R5");
    run_update(4'h7, 12'hFFF, 1'b1, 1, 1, 1, 12'h111, "R5");
    run_update(4'hF, 12'h000, 1'b1, 1, 2, 2, 12'h221, "R3");
  endtask

  task automatic test_zero_phases();
    run_update(4'h2, 12'h456, 1'b1, 0, 0, 0, 12'h000, "R6");
    run_update(4'h5, 12'h789, 1'b1, 0, 3, 0, 12'h030, "R6");
    run_update(4'h9, 12'h321, 1'b1, 2, 0, 1, 12'h102, "R6");
  endtask

  task automatic test_backpressure();
    int gap = 0;
    @(negedge clk);
    req_valid = 1'b1; req_chan = 4'h6; req_code = 12'h6A6; req_fast = 1'b1;
    fast_waits = 12'h011;
    @(negedge clk);
    req_chan = 4'hB; req_code = 12'hB0B;
    while (busy) @(negedge clk);
    while (!busy && gap < 10) begin gap++; @(negedge clk); end
    req_valid = 1'b0;
    check(gap == 1, "R8", "idle gap", gap, 1);
    check(dac_load && dac_data == 12'hB0B, "R8", "held request data",
          int'(dac_data), 12'hB0B);
    check(mux_addr == 4'hB, "R8", "held request channel", int'(mux_addr), 4'hB);
    while (busy) @(negedge clk);
  endtask

  task automatic wait_rel(input int n);
    while (cyc - rel_cyc < n) @(negedge clk);
  endtask

  task automatic test_rate(input int nfast, input int nnorm, input int exp,
                           input string req);
    do_reset();
    for (int i = 0; i < nfast; i++)
      run_update(4'(i), 12'(i * 7), 1'b1, 1, 1, 0, 12'h011, "R5");
    for (int i = 0; i < nnorm; i++)
      run_update(4'(i), 12'(i * 3), 1'b0, 4, 8, 8, 12'h011, "R4");
    wait_rel(WIN + 50);
    check(rate_count == RW'(exp), req, "window count", int'(rate_count), exp);
    wait_rel(2 * WIN + 50);
    check(rate_count == 0, "R9", "empty window", int'(rate_count), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog: actual hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    do_reset();
    test_normal();
    test_fast();
    test_zero_phases();
    test_backpressure();
    test_rate(5, 0, 5, "R9");
    test_rate(3, 3, 3, "R9");
    test_rate(20, 0, 15, "R10");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule